// File: doc/BRIEF.md
# Asynchronous Static RAM Byte-Lane Controller

This block lets synchronous logic use an external asynchronous static RAM of 64K words by 16 bits, organised as two 8-bit byte lanes. The host presents one request at a time: a read/write flag, a word address, write data and one enable per byte lane. The controller turns it into the RAM's active-low strobes, holds each phase for a whole number of clock cycles derived from nanosecond limits, and answers with a one-cycle done pulse. For reads it also returns the selected lanes, with unselected lanes forced to zero.

The data bus is split into an outgoing word, an incoming word and a drive enable, so a pad ring can build the bidirectional pins. The controller keeps its own drivers off until the RAM's outputs have had time to float after a read, and never drives while the RAM's output enable is active.

Phase lengths come from the clock period and the access, write-pulse, data-setup and float limits. Each one is rounded up to whole cycles, with a floor of one cycle.

Top module: `sram_lane_ctrl`

## Requirements
- R1: After reset, chip select, output enable, write enable and both lane selects are high (inactive), the drive enable and done are low, and ready is high.
- R2: A read holds chip select and output enable low, with write enable high, for the access cycle count (4 cycles at the default 8 ns clock and 25 ns access). Lane select n is low exactly when byte enable n is 1 (enable bit 0 is the lower byte, bits 7:0; bit 1 is the upper byte, bits 15:8). Done rises 4 cycles after the accept edge. The returned word carries the RAM data of the selected lanes, sampled on the last access cycle.
- R3: A read with both byte enables 0 keeps both lane selects high and returns the word 0.
- R4: A write with at least one byte enable set holds chip select and write enable low, with the lane selects as in R2, for the write-pulse cycle count (3 cycles by default). Output enable stays high throughout. The write data is driven from the cycle write enable falls until one cycle after it rises, and done follows 4 cycles after the accept edge.
- R5: A write with both byte enables 0 asserts no strobe, drives nothing, leaves the RAM unchanged, and raises done on the accept edge itself.
- R6: After a read, the drive enable rises only when output enable has been high for the float cycle count (2 by default). A write accepted in the cycle right after a read's done therefore starts one cycle late. A write accepted later starts at once.
- R7: While chip select and write enable are both low, the address does not change, and while chip select is low it equals the accepted request's address.
- R8: Ready is high only while idle. A request presented while busy is ignored and causes no strobe.
- R9: A read that immediately follows a write needs no extra turnaround and keeps the R2 timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 16 | Word address |
| req_wdata | input | 16 | Write data |
| req_be | input | 2 | Byte enables, bit 0 lower lane, bit 1 upper lane |
| req_ready | output | 1 | Controller idle, request will be taken |
| resp_done | output | 1 | One-cycle completion pulse |
| resp_rdata | output | 16 | Read word, unselected lanes zero |
| mem_addr | output | 16 | RAM address |
| mem_cs_n | output | 1 | RAM chip select, active low |
| mem_oe_n | output | 1 | RAM output enable, active low |
| mem_we_n | output | 1 | RAM write enable, active low |
| mem_lb_n | output | 1 | RAM lower-byte select, active low |
| mem_ub_n | output | 1 | RAM upper-byte select, active low |
| mem_dout | output | 16 | Data toward the RAM |
| mem_din | input | 16 | Data from the RAM |
| mem_dout_en | output | 1 | Enable for the controller's data drivers |

## Verification
A phase counter loaded with the wrong count shows within one transaction as a strobe window shorter or longer than its limit, or as done arriving on the wrong edge. A lane-select or masking fault shows up as a wrong byte in the very next read, because the bench model returns filler bytes on lanes that are not selected. A float guard that clears too early raises the drive enable one cycle after output enable rises, on the first write that closely follows a read. Stale address or strobe state turns up as an address change under an active write, or as a strobe outside a request.

// File: rtl/sram_ctrl_pkg.sv
// Shared types and helpers for the static RAM byte-lane controller.
// Assumes limits and clock period are given in whole nanoseconds.
package sram_ctrl_pkg;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_READ  = 3'd1,
        ST_TURN  = 3'd2,
        ST_WRITE = 3'd3,
        ST_WREC  = 3'd4
    } ctrl_state_e;

    // Round a nanosecond limit up to whole clock cycles, never below one.
    function automatic int unsigned ns_to_cycles(input int unsigned limit_ns,
                                                 input int unsigned period_ns);
        int unsigned c;
        c = (limit_ns + period_ns - 1) / period_ns;
        if (c < 1) c = 1;
        return c;
    endfunction

    function automatic int unsigned max2(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/sram_phase_timer.sv
// Down-counter that times one access or write phase.
// Loaded with (cycles - 1) on the edge that opens the phase; expired is
// high during the last cycle of the phase. Holds at zero otherwise.
module sram_phase_timer #(
    parameter int unsigned CNT_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             expired
);
    logic [CNT_W-1:0] cnt_q;

    // Count down the remaining cycles of the current phase.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign expired = (cnt_q == '0);

endmodule

// File: rtl/sram_float_guard.sv
// Tracks how long the RAM's outputs have been released after a read.
// arm pulses on the edge that raises output enable; clear goes high once
// HZ_CYC edges have passed with output enable high. Assumes no new read
// starts while the count runs (the controller only reads from idle).
module sram_float_guard #(
    parameter int unsigned HZ_CYC = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic arm,
    output logic clear
);
    localparam int unsigned GW = (HZ_CYC > 1) ? $clog2(HZ_CYC) : 1;

    logic [GW-1:0] left_q;

    // Restart the float window at each read end, then run it down.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            left_q <= '0;
        end else if (arm) begin
            left_q <= GW'(HZ_CYC - 1);
        end else if (left_q != '0) begin
            left_q <= left_q - 1'b1;
        end
    end

    assign clear = (left_q == '0);

endmodule

// File: rtl/sram_read_merge.sv
// Builds the returned read word from the RAM input bus.
// A lane whose select is inactive (high) contributes zeros.
module sram_read_merge #(
    parameter int unsigned LANES  = 2,
    parameter int unsigned LANE_W = 8
) (
    input  logic [LANES*LANE_W-1:0] din,
    input  logic [LANES-1:0]        sel_n,
    output logic [LANES*LANE_W-1:0] merged
);
    for (genvar l = 0; l < LANES; l++) begin : g_lane
        // Pass the lane only when its select is active.
        assign merged[l*LANE_W +: LANE_W] = sel_n[l] ? '0 : din[l*LANE_W +: LANE_W];
    end

endmodule

// File: rtl/sram_lane_ctrl.sv
// Synchronous controller for an asynchronous 2-lane static RAM.
// One request at a time, taken only while idle. All RAM-side outputs are
// registered. Assumes mem_din is stable by the last access cycle's edge
// when the access limit is met, and that the pads tri-state mem_dout when
// mem_dout_en is low.
module sram_lane_ctrl
    import sram_ctrl_pkg::*;
#(
    parameter int unsigned ADDR_W        = 16,
    parameter int unsigned LANE_W        = 8,
    parameter int unsigned CLK_PERIOD_NS = 8,
    parameter int unsigned T_AA_NS       = 25,
    parameter int unsigned T_WP_NS       = 20,
    parameter int unsigned T_DW_NS       = 15,
    parameter int unsigned T_HZ_NS       = 12
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  req_valid,
    input  logic                  req_write,
    input  logic [ADDR_W-1:0]     req_addr,
    input  logic [2*LANE_W-1:0]   req_wdata,
    input  logic [1:0]            req_be,
    output logic                  req_ready,
    output logic                  resp_done,
    output logic [2*LANE_W-1:0]   resp_rdata,
    output logic [ADDR_W-1:0]     mem_addr,
    output logic                  mem_cs_n,
    output logic                  mem_oe_n,
    output logic                  mem_we_n,
    output logic                  mem_lb_n,
    output logic                  mem_ub_n,
    output logic [2*LANE_W-1:0]   mem_dout,
    input  logic [2*LANE_W-1:0]   mem_din,
    output logic                  mem_dout_en
);
    localparam int unsigned LANES   = 2;
    localparam int unsigned DATA_W  = LANES * LANE_W;
    localparam int unsigned AA_CYC  = ns_to_cycles(T_AA_NS, CLK_PERIOD_NS);
    localparam int unsigned WP_CYC  = ns_to_cycles(T_WP_NS, CLK_PERIOD_NS);
    localparam int unsigned DW_CYC  = ns_to_cycles(T_DW_NS, CLK_PERIOD_NS);
    localparam int unsigned HZ_CYC  = ns_to_cycles(T_HZ_NS, CLK_PERIOD_NS);
    // Write strobe covers pulse width and data setup; strobe plus the
    // recovery cycle must also cover the cycle time (equal to access).
    localparam int unsigned WR_CYC  = max2(max2(WP_CYC, DW_CYC), AA_CYC - 1);
    localparam int unsigned PH_MAX  = max2(AA_CYC, WR_CYC);
    localparam int unsigned CNT_W   = $clog2(PH_MAX + 1);

    ctrl_state_e          state_q;
    logic [LANES-1:0]     sel_n_q;
    logic [LANES-1:0]     pend_be_q;
    logic [LANES-1:0]     wr_be;
    logic                 start_rd;
    logic                 start_wr;
    logic                 rd_last;
    logic                 wr_last;
    logic                 ph_load;
    logic [CNT_W-1:0]     ph_val;
    logic                 ph_expired;
    logic                 float_clear;
    logic [DATA_W-1:0]    merged;

    // Decode which phase opens on the coming edge.
    always_comb begin
        wr_be    = (state_q == ST_TURN) ? pend_be_q : req_be;
        start_rd = (state_q == ST_IDLE) && req_valid && !req_write;
        start_wr = float_clear &&
                   (((state_q == ST_IDLE) && req_valid && req_write && (req_be != '0)) ||
                    (state_q == ST_TURN));
        rd_last  = (state_q == ST_READ)  && ph_expired;
        wr_last  = (state_q == ST_WRITE) && ph_expired;
        ph_load  = start_rd || start_wr;
        ph_val   = start_rd ? CNT_W'(AA_CYC - 1) : CNT_W'(WR_CYC - 1);
    end

    sram_phase_timer #(
        .CNT_W    (CNT_W)
    ) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (ph_load),
        .load_val (ph_val),
        .expired  (ph_expired)
    );

    sram_float_guard #(
        .HZ_CYC   (HZ_CYC)
    ) u_guard (
        .clk      (clk),
        .rst_n    (rst_n),
        .arm      (rd_last),
        .clear    (float_clear)
    );

    sram_read_merge #(
        .LANES    (LANES),
        .LANE_W   (LANE_W)
    ) u_merge (
        .din      (mem_din),
        .sel_n    (sel_n_q),
        .merged   (merged)
    );

    // Sequence the RAM strobes, the data drivers and the host response.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q     <= ST_IDLE;
            mem_addr    <= '0;
            mem_cs_n    <= 1'b1;
            mem_oe_n    <= 1'b1;
            mem_we_n    <= 1'b1;
            sel_n_q     <= '1;
            pend_be_q   <= '0;
            mem_dout    <= '0;
            mem_dout_en <= 1'b0;
            resp_done   <= 1'b0;
            resp_rdata  <= '0;
        end else begin
            resp_done <= 1'b0;
            if (start_wr) begin
                mem_cs_n    <= 1'b0;
                mem_we_n    <= 1'b0;
                sel_n_q     <= ~wr_be;
                mem_dout_en <= 1'b1;
                state_q     <= ST_WRITE;
            end
            case (state_q)
                ST_IDLE: begin
                    if (req_valid) begin
                        if (!req_write) begin
                            mem_addr <= req_addr;
                            mem_cs_n <= 1'b0;
                            mem_oe_n <= 1'b0;
                            sel_n_q  <= ~req_be;
                            state_q  <= ST_READ;
                        end else if (req_be == '0) begin
                            resp_done <= 1'b1;
                        end else begin
                            mem_addr  <= req_addr;
                            mem_dout  <= req_wdata;
                            pend_be_q <= req_be;
                            if (!float_clear) state_q <= ST_TURN;
                        end
                    end
                end
                ST_READ: begin
                    if (rd_last) begin
                        resp_rdata <= merged;
                        mem_cs_n   <= 1'b1;
                        mem_oe_n   <= 1'b1;
                        sel_n_q    <= '1;
                        resp_done  <= 1'b1;
                        state_q    <= ST_IDLE;
                    end
                end
                ST_TURN: begin
                    // start_wr above leaves this state once the float window ends
                end
                ST_WRITE: begin
                    if (wr_last) begin
                        mem_cs_n <= 1'b1;
                        mem_we_n <= 1'b1;
                        sel_n_q  <= '1;
                        state_q  <= ST_WREC;
                    end
                end
                ST_WREC: begin
                    mem_dout_en <= 1'b0;
                    resp_done   <= 1'b1;
                    state_q     <= ST_IDLE;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign req_ready = (state_q == ST_IDLE);
    assign mem_lb_n  = sel_n_q[0];
    assign mem_ub_n  = sel_n_q[1];

endmodule

// File: rtl/sram_lane_ctrl_chk.sv
// Protocol checker for the byte-lane controller, bound to its top.
// Watches the RAM-side pins and host handshake only.
module sram_lane_ctrl_chk #(
    parameter int unsigned ADDR_W = 16,
    parameter int unsigned WR_CYC = 3,
    parameter int unsigned HZ_CYC = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              mem_cs_n,
    input logic              mem_oe_n,
    input logic              mem_we_n,
    input logic              mem_lb_n,
    input logic              mem_ub_n,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              mem_dout_en,
    input logic              resp_done,
    input logic              req_ready
);
    localparam int unsigned WW = $clog2(WR_CYC + 2);
    localparam int unsigned HW = $clog2(HZ_CYC + 2);

    logic [WW-1:0] we_lo_cnt;
    logic [HW-1:0] oe_hi_cnt;

    // Count consecutive edges with write enable low, saturating.
    always_ff @(posedge clk) begin
        if (!rst_n)                     we_lo_cnt <= '0;
        else if (mem_we_n)              we_lo_cnt <= '0;
        else if (we_lo_cnt < WW'(WR_CYC)) we_lo_cnt <= we_lo_cnt + 1'b1;
    end

    // Count consecutive edges with output enable high, saturating.
    always_ff @(posedge clk) begin
        if (!rst_n)                     oe_hi_cnt <= HW'(HZ_CYC);
        else if (!mem_oe_n)             oe_hi_cnt <= '0;
        else if (oe_hi_cnt < HW'(HZ_CYC)) oe_hi_cnt <= oe_hi_cnt + 1'b1;
    end

    // R4
    strobe_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_we_n |-> (!mem_cs_n && mem_oe_n && (!mem_lb_n || !mem_ub_n)));

    // R4
    we_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_we_n |-> mem_dout_en);

    // R4
    pulse_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_we_n) |-> (we_lo_cnt >= WW'(WR_CYC)));

    // R6
    drive_oe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_dout_en |-> mem_oe_n);

    // R6
    turnaround_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_dout_en) |-> (oe_hi_cnt >= HW'(HZ_CYC)));

    // R7
    addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_cs_n && !mem_we_n) |=> (mem_we_n || mem_cs_n || $stable(mem_addr)));

    // R8
    done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        resp_done |-> req_ready);

endmodule

bind sram_lane_ctrl sram_lane_ctrl_chk #(
    .ADDR_W (ADDR_W),
    .WR_CYC (WR_CYC),
    .HZ_CYC (HZ_CYC)
) u_chk (.*);

// File: tb/tb_sram_lane_ctrl.sv
// Bench: sweeps addresses and byte-enable patterns against a small RAM model.
`timescale 1ns/1ps
module tb_sram_lane_ctrl;
    localparam int PER   = 8;
    localparam int AA_C  = (25 + PER - 1) / PER;   // 4
    localparam int WR_C  = (20 + PER - 1) / PER;   // 3
    localparam int HZ_C  = (12 + PER - 1) / PER;   // 2

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [15:0] req_addr = '0;
    logic [15:0] req_wdata = '0;
    logic [1:0]  req_be = '0;
    logic        req_ready, resp_done;
    logic [15:0] resp_rdata, mem_addr, mem_dout, mem_din;
    logic        mem_cs_n, mem_oe_n, mem_we_n, mem_lb_n, mem_ub_n, mem_dout_en;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 0;
    bit prev_read = 0;
    logic [15:0] shadow [16];
    logic [15:0] model [16];

    always #(PER/2) clk = ~clk;

    sram_lane_ctrl dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_be(req_be),
        .req_ready(req_ready), .resp_done(resp_done), .resp_rdata(resp_rdata),
        .mem_addr(mem_addr), .mem_cs_n(mem_cs_n), .mem_oe_n(mem_oe_n),
        .mem_we_n(mem_we_n), .mem_lb_n(mem_lb_n), .mem_ub_n(mem_ub_n),
        .mem_dout(mem_dout), .mem_din(mem_din), .mem_dout_en(mem_dout_en)
    );

    // RAM model: writes lanes on a qualified strobe, filler on idle lanes.
    always_ff @(posedge clk) begin
        if (!mem_cs_n && !mem_we_n && mem_dout_en) begin
            if (!mem_lb_n) model[mem_addr[3:0]][7:0]  <= mem_dout[7:0];
            if (!mem_ub_n) model[mem_addr[3:0]][15:8] <= mem_dout[15:8];
        end
    end
    always_comb begin
        mem_din[7:0]  = (!mem_cs_n && !mem_oe_n && mem_we_n && !mem_lb_n) ? model[mem_addr[3:0]][7:0]  : 8'hA5;
        mem_din[15:8] = (!mem_cs_n && !mem_oe_n && mem_we_n && !mem_ub_n) ? model[mem_addr[3:0]][15:8] : 8'h5A;
    end

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [15:0] lane_mask(input logic [15:0] w, input logic [1:0] be);
        return {be[1] ? w[15:8] : 8'h00, be[0] ? w[7:0] : 8'h00};
    endfunction

    // One request, started at a falling edge; returns at the falling edge of done.
    task automatic run_op(input bit wr, input logic [15:0] a, input logic [15:0] d,
                          input logic [1:0] be, output logic [15:0] rd);
        int lat = 0, cs_lo = 0, we_lo = 0, oe_lo = 0, drv = 0, first_drv = 0;
        int exp_lat, exp_first;
        bit addr_ok = 1, sel_ok = 1, dout_ok = 1;
        bit turn = wr && (be != 2'b00) && prev_read;
        exp_lat   = (wr && be == 2'b00) ? 1 : (turn ? 6 : 5);
        exp_first = turn ? 2 : 1;
        req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d; req_be = be;
        @(posedge clk);
        for (int n = 1; n <= 30; n++) begin
            @(negedge clk);
            if (n == 1) req_valid = 1'b0;
            if (!mem_cs_n) begin
                cs_lo++;
                if (mem_addr != a) addr_ok = 0;
                if ({mem_ub_n, mem_lb_n} != ~be) sel_ok = 0;
            end
            if (!mem_we_n) we_lo++;
            if (!mem_oe_n) oe_lo++;
            if (mem_dout_en) begin
                drv++;
                if (first_drv == 0) first_drv = n;
                if (mem_dout != d) dout_ok = 0;
            end
            if (resp_done) begin lat = n; break; end
        end
        rd = resp_rdata;
        chk(addr_ok, "R7 address held under strobe", 32'(mem_addr), 32'(a));
        if (!wr) begin
            chk(lat == AA_C + 1, "R2 read done latency", 32'(lat), 32'(AA_C + 1));
            chk(cs_lo == AA_C && oe_lo == AA_C, "R2 read strobe window", 32'(cs_lo), 32'(AA_C));
            chk(we_lo == 0 && drv == 0, "R2 read no write/drive", 32'(we_lo + drv), 0);
            chk(sel_ok, "R2 read lane selects", 32'({mem_ub_n, mem_lb_n}), 32'(~be));
        end else if (be != 2'b00) begin
            chk(lat == exp_lat, "R4/R6 write done latency", 32'(lat), 32'(exp_lat));
            chk(we_lo == WR_C && cs_lo == WR_C, "R4 write pulse width", 32'(we_lo), 32'(WR_C));
            chk(oe_lo == 0, "R4 output enable high in write", 32'(oe_lo), 0);
            chk(drv == WR_C + 1 && dout_ok, "R4 write data drive window", 32'(drv), 32'(WR_C + 1));
            chk(first_drv == exp_first, "R6 drive start after float", 32'(first_drv), 32'(exp_first));
            chk(sel_ok, "R4 write lane selects", 32'({mem_ub_n, mem_lb_n}), 32'(~be));
        end else begin
            chk(lat == 1, "R5 no-op write done latency", 32'(lat), 1);
            chk(cs_lo == 0 && we_lo == 0 && drv == 0, "R5 no-op write strobes", 32'(cs_lo + we_lo + drv), 0);
        end
        prev_read = !wr;
    endtask

    task automatic do_write(input int idx, input logic [15:0] d, input logic [1:0] be);
        logic [15:0] rd;
        run_op(1'b1, 16'(idx * 16'h1111), d, be, rd);
        if (be[0]) shadow[idx][7:0]  = d[7:0];
        if (be[1]) shadow[idx][15:8] = d[15:8];
    endtask

    task automatic do_read(input int idx, input logic [1:0] be);
        logic [15:0] rd, exp;
        run_op(1'b0, 16'(idx * 16'h1111), 16'h0, be, rd);
        exp = lane_mask(shadow[idx], be);
        if (be == 2'b00) chk(rd == 16'h0, "R3 read with no lanes", 32'(rd), 0);
        else             chk(rd == exp, "R2 read data lanes", 32'(rd), 32'(exp));
    endtask

    initial begin
        logic [15:0] rd;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk({mem_cs_n, mem_oe_n, mem_we_n, mem_lb_n, mem_ub_n} == 5'h1F, "R1 strobes idle in reset",
            32'({mem_cs_n, mem_oe_n, mem_we_n, mem_lb_n, mem_ub_n}), 32'h1F);
        chk(!mem_dout_en && !resp_done, "R1 drive and done low", 32'({mem_dout_en, resp_done}), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(req_ready, "R1 ready after reset", 32'(req_ready), 1);

        // R4: full-word writes sweeping all addresses
        for (int i = 0; i < 16; i++) do_write(i, 16'(i * 16'h03A5) ^ 16'h5C00, 2'b11);
        // R2, R3, R9: every lane pattern on every address
        for (int i = 0; i < 16; i++)
            for (int b = 0; b < 4; b++) do_read(i, 2'(b));
        // R4, R6: partial writes right after reads, each read back
        for (int i = 0; i < 16; i++) begin
            do_write(i, ~16'(i * 16'h0F1E), 2'((i % 3) + 1));
            for (int b = 1; b < 4; b++) do_read(i, 2'(b));
        end
        // R5: no-op writes leave the RAM alone
        for (int i = 0; i < 4; i++) begin
            do_write(i, 16'hFFFF, 2'b00);
            do_read(i, 2'b11);
        end
        // R6: write after a gap long enough for the float window starts at once
        do_read(5, 2'b11);
        repeat (HZ_C) @(negedge clk);
        prev_read = 0;
        do_write(5, 16'hC3A1, 2'b11);
        do_read(5, 2'b11);

        // R8: requests while busy are ignored
        req_valid = 1'b1; req_write = 1'b0; req_addr = 16'h7777; req_be = 2'b11;
        @(posedge clk);
        @(negedge clk);
        req_write = 1'b1; req_addr = 16'h9999; req_wdata = 16'hDEAD;
        chk(!req_ready, "R8 ready low while busy", 32'(req_ready), 0);
        @(negedge clk);
        chk(!req_ready && mem_addr == 16'h7777, "R8 busy request ignored", 32'(mem_addr), 32'h7777);
        req_valid = 1'b0;
        for (int n = 0; n < 10 && !resp_done; n++) @(negedge clk);
        chk(resp_rdata == shadow[7], "R8 read data through busy request", 32'(resp_rdata), 32'(shadow[7]));
        repeat (6) begin
            @(negedge clk);
            chk(mem_cs_n && mem_we_n, "R8 no strobe from ignored request", 32'({mem_cs_n, mem_we_n}), 3);
        end
        prev_read = 0;
        do_read(9, 2'b11);

        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog expired actual=%0h expected=%0h", 0, 1);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule